// File: doc/BRIEF.md
# Chip-Synchronous Infrared Subcarrier Modulator

This block turns a serial stream of chips into the on/off drive for an infrared emitter. A chip valued 1 is sent as a burst of subcarrier square wave. A chip valued 0 is sent as silence. The chip clock and the subcarrier both come from the one system clock through a half-period divider. Because one chip lasts exactly twenty subcarrier half-periods, every chip holds ten whole subcarrier cycles. The subcarrier phase restarts at every chip boundary. As a result, a run of N lit chips comes out as one unbroken burst of 10×N cycles.

The block pulls chips from an upstream encoder. A one-cycle request pulse, `chip_req`, marks the last system-clock cycle of each chip. The encoder presents the next chip value on `chip_bit` during that cycle, and the block latches it at the closing edge.

The `enable` input gates the whole block. While it is low, the output is held low, no requests are issued, and the dividers and the chip register are cleared. When it rises again, a fresh chip period begins.

Top module: `sc_chip_modulator`

## Requirements
- R1: A chip latched as 0 keeps `emit` low for every clock cycle of that chip.
- R2: A chip latched as 1 drives `emit` as a square wave of CYC_PER_CHIP (10) cycles. Each half lasts HALF_DIV clocks, the high half comes first, and the chip has 10×HALF_DIV high clocks and 10 rising edges.
- R3: In the first clock cycle of every chip latched as 1, `emit` is high, so each burst starts at the chip boundary.
- R4: `chip_req` is high for exactly one clock per chip. It falls in the last cycle of the chip, and chips are 2×CYC_PER_CHIP×HALF_DIV clocks apart. The value on `chip_bit` in that cycle sets the next chip.
- R5: Adjacent lit chips form one continuous burst. A run of N lit chips (N from 1 to 8) gives 10×N rising edges and 10×N×HALF_DIV high clocks, with no low stretch longer than one half-period.
- R6: While `enable` is low, `emit` and `chip_req` are low in that same cycle, and the dividers and the chip register are cleared.
- R7: After `enable` rises, the first chip is silent whatever `chip_bit` holds. The first `chip_req` appears in the (2×CYC_PER_CHIP×HALF_DIV−1)th clock cycle after the first rising edge at which `enable` is sampled high.
- R8: During reset, `emit` and `chip_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run control. Low forces silence and clears the dividers |
| chip_bit | input | 1 | Next chip value, sampled in the cycle where `chip_req` is high |
| chip_req | output | 1 | One-cycle request for the next chip, in the last cycle of each chip |
| emit | output | 1 | Gated subcarrier drive for the emitter |

## Verification
A wrong half-period count or half-period index shows up within one chip. It appears as a wrong number of high clocks or rising edges in a lit chip, and as `chip_req` arriving off its 2×CYC_PER_CHIP×HALF_DIV-clock spacing. A chip register that latches at the wrong edge, or misses a clear, shows up in the next chip. That chip then emits when it should be dark, or stays dark when it should emit. It also shows up as a lit first chip after `enable` rises. A phase that fails to restart at a chip boundary breaks the burst-start check in the first cycle of the following lit chip.

// File: rtl/sc_mod_pkg.sv
package sc_mod_pkg;

  typedef enum logic {
    CHIP_DARK = 1'b0,
    CHIP_LIT  = 1'b1
  } chip_lvl_e;

  typedef struct packed {
    logic half_tick;
    logic chip_end;
  } phase_t;

endpackage

// File: rtl/sc_half_div.sv
module sc_half_div #(
  parameter int HALF_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF_DIV - 1);

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_d;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign half_tick = run & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sc_chip_seq.sv
module sc_chip_seq #(
  parameter int HALVES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_tick,
  output logic half_odd,
  output logic chip_end
);

  localparam int IW = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam logic [IW-1:0] LAST = IW'(HALVES - 1);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic          at_last;

  assign at_last  = (idx_q == LAST);
  assign chip_end = run & half_tick & at_last;
  assign half_odd = idx_q[0];

  always_comb begin
    idx_d = idx_q;
    if (!run) begin
      idx_d = '0;
    end else if (half_tick) begin
      if (at_last) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/sc_chip_gate.sv
module sc_chip_gate
  import sc_mod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic chip_end,
  input  logic chip_bit,
  input  logic half_odd,
  output logic emit
);

  chip_lvl_e lvl_q;
  chip_lvl_e lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!run) begin
      lvl_d = CHIP_DARK;
    end else if (chip_end) begin
      lvl_d = chip_bit ? CHIP_LIT : CHIP_DARK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= CHIP_DARK;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  // High half first: even half index drives the subcarrier high.
  assign emit = run & (lvl_q == CHIP_LIT) & ~half_odd;

endmodule

// File: rtl/sc_chip_modulator.sv
module sc_chip_modulator
  import sc_mod_pkg::*;
#(
  parameter int HALF_DIV     = 16,
  parameter int CYC_PER_CHIP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic chip_bit,
  output logic chip_req,
  output logic emit
);

  localparam int HALVES = 2 * CYC_PER_CHIP;

  logic [1:0] rst_q;
  logic       rst_s;
  phase_t     ph;
  logic       half_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_s = rst_q[1];

  sc_half_div #(.HALF_DIV(HALF_DIV)) u_half (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (enable),
    .half_tick (ph.half_tick)
  );

  sc_chip_seq #(.HALVES(HALVES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (enable),
    .half_tick (ph.half_tick),
    .half_odd  (half_odd),
    .chip_end  (ph.chip_end)
  );

  sc_chip_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_s),
    .run      (enable),
    .chip_end (ph.chip_end),
    .chip_bit (chip_bit),
    .half_odd (half_odd),
    .emit     (emit)
  );

  assign chip_req = ph.chip_end;

endmodule

// File: rtl/sc_chip_modulator_chk.sv
module sc_chip_modulator_chk (
  input logic clk,
  input logic rst_s,
  input logic enable,
  input logic chip_bit,
  input logic chip_req,
  input logic emit,
  input logic half_tick
);

  // R1: a chip latched as 0 starts dark
  a_r1_dark_chip: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(chip_req) && !$past(chip_bit)) |-> !emit);

  // R3: a chip latched as 1 starts high
  a_r3_burst_start: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(chip_req) && $past(chip_bit) && enable) |-> emit);

  // R2: output only moves on half-period boundaries while running
  a_r2_half_stable: assert property (@(posedge clk) disable iff (!rst_s)
    (enable && $past(enable) && !$past(half_tick)) |-> $stable(emit));

  // R4: request lasts a single cycle
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_s)
    chip_req |=> !chip_req);

  // R6: disabled block is silent
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !enable |-> (!emit && !chip_req));

endmodule

bind sc_chip_modulator sc_chip_modulator_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .enable    (enable),
  .chip_bit  (chip_bit),
  .chip_req  (chip_req),
  .emit      (emit),
  .half_tick (ph.half_tick)
);

// File: tb/sc_chip_modulator_tb.sv
`timescale 1ns/1ps
module sc_chip_modulator_tb;

  localparam int H    = 3;
  localparam int CYC  = 10;
  localparam int CHIP = 2 * CYC * H;

  logic clk;
  logic rst_n;
  logic enable;
  logic chip_bit;
  logic chip_req;
  logic emit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sc_chip_modulator #(.HALF_DIV(H), .CYC_PER_CHIP(CYC)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .chip_bit (chip_bit),
    .chip_req (chip_req),
    .emit     (emit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: outputs quiet while reset is held
  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; chip_bit = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 emit in reset", emit, 0);
    chk("R8 chip_req in reset", chip_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R7: first chip after enable is silent, first request at CHIP-1
  task automatic t_start();
    int j = 0;
    int highs = 0;
    chip_bit = 1'b1;
    enable = 1'b1;
    while (j < 4 * CHIP) begin
      @(negedge clk);
      j++;
      if (emit) highs++;
      if (chip_req) break;
    end
    chk("R7 first request cycle", j, CHIP - 1);
    chk("R7 first chip silent", highs, 0);
  endtask

  // R1..R5: drive a chip pattern; enter and leave at a negedge with chip_req high
  task automatic run_chips(input logic [63:0] pat, input int n);
    logic prev = emit;
    int run = 0, bhigh = 0, brise = 0;
    for (int k = 0; k < n; k++) begin
      int high = 0, rise = 0, reqs = 0;
      logic first = 1'b0, lastreq = 1'b0;
      chip_bit = pat[k];
      for (int i = 0; i < CHIP; i++) begin
        @(negedge clk);
        if (i == 0) first = emit;
        if (emit) high++;
        if (emit && !prev) rise++;
        prev = emit;
        if (chip_req) reqs++;
        if (i == CHIP - 1) lastreq = chip_req;
      end
      if (pat[k]) begin
        chk("R2 high clocks in lit chip", high, CYC * H);
        chk("R2 rising edges in lit chip", rise, CYC);
        chk("R3 lit chip starts high", first, 1);
        run++; bhigh += high; brise += rise;
      end else begin
        chk("R1 dark chip high clocks", high, 0);
      end
      chk("R4 requests per chip", reqs, 1);
      chk("R4 request in last cycle", lastreq, 1);
      if ((!pat[k] || k == n - 1) && run > 0) begin
        chk("R5 burst rising edges", brise, CYC * run);
        chk("R5 burst high clocks", bhigh, CYC * H * run);
        run = 0; bhigh = 0; brise = 0;
      end
    end
  endtask

  task automatic t_mixed();
    // chips in time order: 0 1 0 1 1 0
    run_chips(64'b011010, 6);
  endtask

  task automatic t_runs();
    logic [63:0] pat = '0;
    int idx = 0;
    for (int r = 1; r <= 8; r++) begin
      for (int j = 0; j < r; j++) begin
        pat[idx] = 1'b1;
        idx++;
      end
      idx++;
    end
    run_chips(pat, idx);
  endtask

  // R6: disabling mid-burst silences at once, then restart clears dividers
  task automatic t_disable();
    int bad = 0;
    int j = 0;
    int highs = 0;
    chip_bit = 1'b1;
    repeat (CHIP / 3) @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R6 emit low in same cycle", emit, 0);
    chk("R6 chip_req low in same cycle", chip_req, 0);
    for (int i = 0; i < 2 * CHIP; i++) begin
      @(negedge clk);
      if (emit || chip_req) bad++;
    end
    chk("R6 quiet while disabled", bad, 0);
    enable = 1'b1;
    while (j < 4 * CHIP) begin
      @(negedge clk);
      j++;
      if (emit) highs++;
      if (chip_req) break;
    end
    chk("R6 dividers restarted", j, CHIP - 1);
    chk("R7 silent chip after re-enable", highs, 0);
    run_chips(64'b01, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start();
    t_mixed();
    t_runs();
    t_disable();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule